// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block gives software a bank of general-purpose pins through a small 32-bit register bus. Each pin can be read, driven, or left as an input, and can request an interrupt. Pin inputs are first resynchronised to the block clock by a two-flop chain. Every register that the bench and software rely on sits at a fixed byte offset that is decoded from `addr_i`.

Each pin has two interrupt paths that run side by side. The level path is combinational and tracks the synchronised input through a per-pin polarity and a per-pin mask. The edge path compares the synchronised input with its value one cycle earlier, so only the selected edge direction is caught. A caught edge sets a sticky event bit, and software clears that bit by writing a one to it. A pin is pending when either path is active. The OR of all pending pins is the summary status bit. A single global enable gates that bit onto a registered interrupt line.

Writes take effect on the clock edge where `wr_en_i` is high. Reads are combinational from `addr_i`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every writable register reads 0. `pin_oe_o`, `pin_out_o` and `irq_o` are 0, so every pin is an input and every interrupt is masked.
- R2: The register at 0x48 holds the per-pin output enables and drives `pin_oe_o`. The register at 0x44 holds output data. `pin_out_o` is the data bit ANDed with the enable bit, and both registers read back what was written.
- R3: Offset 0x40 reads the pin inputs after a two-flop synchroniser. A change driven before clock edge k is readable after edge k+1 and not after edge k. Writes to 0x40 are ignored.
- R4: A pin's level term is (synchronised input XOR polarity bit at 0x50) AND mask bit at 0x54. A polarity bit of 1 therefore makes the level term active when the input is low.
- R5: Edge polarity at 0x64 selects the edge per pin: 0 means rising, 1 means falling. An event bit at 0x58 sets whether or not it is masked. The bit becomes readable after the third clock edge following the pin change. The edge term of a pin is its event bit AND its edge mask bit at 0x5C.
- R6: Writing 0x58 clears each event bit that is written as 1 and leaves each bit that is written as 0 unchanged.
- R7: If a new edge is detected in the same cycle as a clear write to that bit, the event bit remains set.
- R8: Bit 0 at 0x00 is the OR over all pins of (level term OR edge term). It is read-only, and bits 31:1 read 0. It does not depend on the global enable.
- R9: Bit 0 at 0x04 is the global enable. `irq_o` is a register loaded each cycle with the global enable AND the summary bit. `irq_o` rises one cycle after the enable write, and it falls one cycle after the last pending term is masked or the enable is cleared.
- R10: Unmapped offsets read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_in_i | input | NUM_PINS | Asynchronous pin inputs |
| pin_out_o | output | NUM_PINS | Pin output values, forced to 0 when not enabled |
| pin_oe_o | output | NUM_PINS | Pin output enables |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two things can meet in one cycle: a software write-one-to-clear on the event register, and a freshly detected edge on the same pin. The bench first latches an event on a pin and then drops the pin. It then raises the pin again and times the clear write so that the write's capture edge is exactly the edge that registers the new transition. Reading the event register afterwards must show the bit still set. A second, plain clear must then empty it, which shows that clearing works when no edge arrives alongside it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_TOP_EN = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIN    = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_DOUT   = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_OE     = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_LPOL   = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_LMASK  = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_EVT    = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_EMASK  = 8'h5C;
  localparam logic [ADDR_W-1:0] OFF_EPOL   = 8'h64;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] async_i,
  output logic [NUM_PINS-1:0] sync_o,
  output logic [NUM_PINS-1:0] prev_o
);
  logic [STAGES-1:0][NUM_PINS-1:0] chain_q;
  logic [NUM_PINS-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] sync_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] fall_sel_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] evt_o
);
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] evt_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign hit[g] = fall_sel_i[g] ? (prev_i[g] & ~sync_i[g])
                                  : (sync_i[g] & ~prev_i[g]);
    // new edge wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q[g] <= 1'b0;
      else         evt_q[g] <= (evt_q[g] & ~clr_i[g]) | hit[g];
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] din_i,
  input  logic [NUM_PINS-1:0] lpol_i,
  input  logic [NUM_PINS-1:0] lmask_i,
  input  logic [NUM_PINS-1:0] evt_i,
  input  logic [NUM_PINS-1:0] emask_i,
  input  logic                top_en_i,
  output logic                summary_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] lvl_term;
  logic [NUM_PINS-1:0] edge_term;
  logic                irq_q;

  assign lvl_term  = (din_i ^ lpol_i) & lmask_i;
  assign edge_term = evt_i & emask_i;
  assign summary_o = |(lvl_term | edge_term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= top_en_i & summary_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [7:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] dout_q, oe_q, lpol_q, lmask_q, emask_q, epol_q;
  logic                top_en_q;
  logic [NUM_PINS-1:0] pin_sync, pin_prev, evt_q, evt_clr;
  logic                summary;

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_in_i),
    .sync_o (pin_sync),
    .prev_o (pin_prev)
  );

  assign evt_clr = (wr_en_i && addr_i == OFF_EVT) ? wdata_i[NUM_PINS-1:0] : '0;

  gpio_edge_evt #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (pin_sync),
    .prev_i    (pin_prev),
    .fall_sel_i(epol_q),
    .clr_i     (evt_clr),
    .evt_o     (evt_q)
  );

  gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .din_i    (pin_sync),
    .lpol_i   (lpol_q),
    .lmask_i  (lmask_q),
    .evt_i    (evt_q),
    .emask_i  (emask_q),
    .top_en_i (top_en_q),
    .summary_o(summary),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      oe_q     <= '0;
      lpol_q   <= '0;
      lmask_q  <= '0;
      emask_q  <= '0;
      epol_q   <= '0;
      top_en_q <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_TOP_EN: top_en_q <= wdata_i[0];
        OFF_DOUT:   dout_q   <= wdata_i[NUM_PINS-1:0];
        OFF_OE:     oe_q     <= wdata_i[NUM_PINS-1:0];
        OFF_LPOL:   lpol_q   <= wdata_i[NUM_PINS-1:0];
        OFF_LMASK:  lmask_q  <= wdata_i[NUM_PINS-1:0];
        OFF_EMASK:  emask_q  <= wdata_i[NUM_PINS-1:0];
        OFF_EPOL:   epol_q   <= wdata_i[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_STATUS: rdata_o[0]            = summary;
      OFF_TOP_EN: rdata_o[0]            = top_en_q;
      OFF_DIN:    rdata_o[NUM_PINS-1:0] = pin_sync;
      OFF_DOUT:   rdata_o[NUM_PINS-1:0] = dout_q;
      OFF_OE:     rdata_o[NUM_PINS-1:0] = oe_q;
      OFF_LPOL:   rdata_o[NUM_PINS-1:0] = lpol_q;
      OFF_LMASK:  rdata_o[NUM_PINS-1:0] = lmask_q;
      OFF_EVT:    rdata_o[NUM_PINS-1:0] = evt_q;
      OFF_EMASK:  rdata_o[NUM_PINS-1:0] = emask_q;
      OFF_EPOL:   rdata_o[NUM_PINS-1:0] = epol_q;
      default: ;
    endcase
  end

  assign pin_oe_o  = oe_q;
  assign pin_out_o = dout_q & oe_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [7:0]          addr_i,
  input logic [NUM_PINS-1:0] pin_out_i,
  input logic [NUM_PINS-1:0] pin_oe_i,
  input logic                irq_i,
  input logic                top_en_i,
  input logic [NUM_PINS-1:0] sync_i,
  input logic [NUM_PINS-1:0] prev_i,
  input logic [NUM_PINS-1:0] evt_i
);
  assert_out_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_i & ~pin_oe_i) == '0);

  assert_evt_needs_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & ~$past(evt_i)) != '0) |-> ($past(sync_i) != $past(prev_i)));

  assert_evt_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(wr_en_i) && $past(addr_i) == OFF_EVT) |-> ((evt_i & $past(evt_i)) == $past(evt_i)));

  assert_irq_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(top_en_i));

  assert_irq_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !top_en_i |=> !irq_i);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .pin_out_i(pin_out_o),
  .pin_oe_i (pin_oe_o),
  .irq_i    (irq_o),
  .top_en_i (top_en_q),
  .sync_i   (pin_sync),
  .prev_i   (pin_prev),
  .evt_i    (evt_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int unsigned N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pout, poe;
  logic         irq;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_in_i(pins),
    .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h64};
    foreach (offs[i]) begin
      rd(offs[i], d);
      chk("R1", $sformatf("reg 0x%0h after reset", offs[i]), d, 0);
    end
    chk("R1", "pin_oe after reset", 32'(poe), 0);
    chk("R1", "pin_out after reset", 32'(pout), 0);
    chk("R1", "irq after reset", 32'(irq), 0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    wr(8'h48, 32'h0F);
    wr(8'h44, 32'hA5);
    chk("R2", "pin_oe", 32'(poe), 32'h0F);
    chk("R2", "pin_out gated by enable", 32'(pout), 32'h05);
    rd(8'h44, d); chk("R2", "dout readback", d, 32'hA5);
    rd(8'h48, d); chk("R2", "oe readback", d, 32'h0F);
    wr(8'h48, 32'h00);
    chk("R2", "pin_out all inputs", 32'(pout), 0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk); pins = 8'h3C;
    rd(8'h40, d); chk("R3", "din after one edge", d, 0);
    rd(8'h40, d); chk("R3", "din after two edges", d, 32'h3C);
    wr(8'h40, 32'hFF);
    rd(8'h40, d); chk("R3", "din ignores write", d, 32'h3C);
    @(negedge clk); pins = '0;
    settle();
    wr(8'h58, 32'hFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h54, 32'h01);
    @(negedge clk); pins[0] = 1'b1;
    settle();
    rd(8'h00, d); chk("R4", "active-high level pending", d, 1);
    wr(8'h50, 32'h01);
    rd(8'h00, d); chk("R4", "inverted polarity, input high", d, 0);
    @(negedge clk); pins[0] = 1'b0;
    settle();
    rd(8'h00, d); chk("R4", "active-low level pending", d, 1);
    wr(8'h54, 32'h00);
    rd(8'h00, d); chk("R8", "masked level not in summary", d, 0);
    wr(8'h50, 32'h00);
    wr(8'h58, 32'hFF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); pins[1] = 1'b1;
    rd(8'h58, d); chk("R5", "event after edge 1", d, 0);
    rd(8'h58, d); chk("R5", "event after edge 2", d, 0);
    rd(8'h58, d); chk("R5", "event after edge 3 (rising)", d, 32'h02);
    rd(8'h00, d); chk("R5", "unmasked event not pending", d, 0);
    wr(8'h58, 32'h02);
    @(negedge clk); pins[1] = 1'b0;
    settle();
    rd(8'h58, d); chk("R5", "falling ignored in rising mode", d, 0);
    wr(8'h64, 32'h02);
    @(negedge clk); pins[1] = 1'b1;
    settle();
    rd(8'h58, d); chk("R5", "rising ignored in falling mode", d, 0);
    @(negedge clk); pins[1] = 1'b0;
    settle();
    rd(8'h58, d); chk("R5", "falling caught", d, 32'h02);
    wr(8'h5C, 32'h02);
    rd(8'h00, d); chk("R8", "masked-in event pending", d, 1);
    wr(8'h5C, 32'h00);
    wr(8'h64, 32'h00);
    wr(8'h58, 32'hFF);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    @(negedge clk); pins[3:2] = 2'b11;
    settle();
    rd(8'h58, d); chk("R6", "two events set", d, 32'h0C);
    wr(8'h58, 32'h04);
    rd(8'h58, d); chk("R6", "clear one bit", d, 32'h08);
    wr(8'h58, 32'h00);
    rd(8'h58, d); chk("R6", "zero write keeps", d, 32'h08);
    wr(8'h58, 32'h08);
    rd(8'h58, d); chk("R6", "clear other bit", d, 0);
    @(negedge clk); pins[3:2] = 2'b00;
    settle();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk); pins[4] = 1'b1;
    settle();
    @(negedge clk); pins[4] = 1'b0;
    settle();
    rd(8'h58, d); chk("R7", "event held before collision", d, 32'h10);
    @(negedge clk); pins[4] = 1'b1;
    @(negedge clk);
    wr(8'h58, 32'h10); // capture edge = edge that registers the new rise
    rd(8'h58, d); chk("R7", "edge beats same-cycle clear", d, 32'h10);
    wr(8'h58, 32'h10);
    rd(8'h58, d); chk("R7", "plain clear afterwards", d, 0);
    @(negedge clk); pins[4] = 1'b0;
    settle();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h54, 32'h20);
    @(negedge clk); pins[5] = 1'b1;
    settle();
    rd(8'h00, d); chk("R8", "summary with global enable off", d, 1);
    chk("R9", "irq held low while disabled", 32'(irq), 0);
    wr(8'h04, 32'h1);
    chk("R9", "irq one cycle after enable write", 32'(irq), 0);
    @(negedge clk); chk("R9", "irq asserted", 32'(irq), 1);
    wr(8'h54, 32'h00);
    chk("R9", "irq still registered high", 32'(irq), 1);
    @(negedge clk); chk("R9", "irq drops after mask", 32'(irq), 0);
    wr(8'h54, 32'h20);
    @(negedge clk); chk("R9", "irq back", 32'(irq), 1);
    wr(8'h04, 32'h0);
    @(negedge clk); chk("R9", "irq drops after disable", 32'(irq), 0);
    rd(8'h04, d); chk("R9", "enable readback", d, 0);
    wr(8'h54, 32'h00);
    @(negedge clk); pins[5] = 1'b0;
    settle();
    wr(8'h58, 32'hFF);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, d); chk("R10", "unmapped 0x4C", d, 0);
    rd(8'h60, d); chk("R10", "unmapped 0x60", d, 0);
    rd(8'h44, d); chk("R10", "dout unchanged by stray write", d, 32'hA5);
    chk("R10", "pin_oe unchanged by stray write", 32'(poe), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_output();
    t_input();
    t_level();
    t_edge();
    t_w1c();
    t_collide();
    t_irq();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule